// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block carries out the unsigned byte multiply and the word-by-byte divide of a small 8-bit processor core. It works over many cycles. The core issues a one-cycle start together with the instruction opcode and the current contents of its accumulator (A) and temporary register (T). The unit captures these operands, iterates on one shared shift-add/shift-subtract datapath, and then raises a one-cycle done pulse. In that cycle the new A and T values and the flag updates are presented.

Both operations share one adder/subtractor, one operand register and one shift register. Each operation has a fixed latency, so the core can schedule around it without looking at status. The multiply runs 8 radix-2 steps and the divide runs 16. Idle padding then makes the done pulse land on exactly the nineteenth or twenty-first edge after the start is taken.

Top module: `muldiv_unit`

## Requirements
- R1: When a start is taken with opcode 0x01 (multiply), the done cycle shows `a_o` = `a_i[7:0]` × `t_i[7:0]` as a 16-bit unsigned product and `t_o` = `t_i`. The upper bytes of `a_i` and `t_i` have no effect on the product.
- R2: For opcode 0x01, `done_o` is high in the cycle that follows the 19th rising edge after the edge that took the start, and it is low in every cycle before that.
- R3: When a start is taken with opcode 0x11 (divide) and `a_i[7:0]` ≠ 0, the done cycle shows `a_o` = {0x00, low byte of `t_i` / `a_i[7:0]`} and `t_o` = {0x00, `t_i` mod `a_i[7:0]`}. The upper byte of `a_i` has no effect.
- R4: For opcode 0x11, `done_o` is high in the cycle that follows the 21st rising edge after the edge that took the start, and it is low in every cycle before that.
- R5: A divide with `a_i[7:0]` = 0 still finishes with the normal divide latency. It returns `a_o` = 0x00FF and `t_o` = `t_i`, and it drives `div_zero_o` high for the done cycle only.
- R6: In the done cycle of a multiply, all four flag write-enables (`we_n_o`, `we_z_o`, `we_v_o`, `we_c_o`) are high. The flags are N = product bit 15, Z = (product = 0), V = 0 and C = 0.
- R7: In the done cycle of a divide the four flag write-enables are low. Outside a done cycle they are always low.
- R8: A start that arrives while `busy_o` is high is ignored. The running operation finishes at its own time with its own result.
- R9: A start whose opcode is neither 0x01 nor 0x11 is ignored. `busy_o` stays low, no done follows, and `a_o`/`t_o` keep their values.
- R10: `done_o` is a one-cycle pulse. `busy_o` is high from the edge that takes a start until the edge that raises `done_o`. `a_o`, `t_o` and the flag outputs change only on the edge that raises `done_o`, and they hold their values after it.
- R11: Synchronous active-low reset clears `busy_o`, `done_o`, `a_o`, `t_o`, `div_zero_o`, the flags and the write-enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| opcode_i | input | 8 | Instruction opcode (0x01 multiply, 0x11 divide) |
| a_i | input | 16 | Accumulator value at start |
| t_i | input | 16 | Temporary register value at start |
| a_o | output | 16 | New accumulator value, valid in done cycle |
| t_o | output | 16 | New temporary register value, valid in done cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divisor was zero, in done cycle |
| flag_n_o | output | 1 | Negative flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_v_o | output | 1 | Overflow flag value |
| flag_c_o | output | 1 | Carry flag value |
| we_n_o | output | 1 | Write-enable for N |
| we_z_o | output | 1 | Write-enable for Z |
| we_v_o | output | 1 | Write-enable for V |
| we_c_o | output | 1 | Write-enable for C |

## Verification
The edge that takes a start is edge k. A multiply's results and flags are due in the cycle after edge k+19, and a divide's are due in the cycle after edge k+21. `busy_o` is due high in the cycle right after edge k. The bench counts edges from edge k and samples on falling edges only. It confirms that `done_o` is still low after edge k+LAT−1 and then checks every output after edge k+LAT, so both an early and a late pulse are caught. The checker also counts busy cycles and compares the count with the latency of the finished operation. The sweeps cover a grid of multiplier and multiplicand bytes, and a grid of dividends against divisors that includes zero. Some of these operations receive extra starts while busy.

// File: rtl/muldiv_pkg.sv
// Package: shared opcodes, operation encoding and flag record for the
// sequential multiply/divide unit. Assumes an 8-bit opcode space.
package muldiv_pkg;

    localparam logic [7:0] OPC_MULU = 8'h01;
    localparam logic [7:0] OPC_DIVU = 8'h11;

    typedef enum logic [0:0] {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/muldiv_ctrl.sv
// Module: sequencing for the multiply/divide unit.
// Decodes the opcode and accepts a start only when idle and the opcode is
// known. It runs a latency countdown and a separate iteration countdown,
// and emits a step strobe for the datapath and a commit strobe one edge
// before done. Assumes ITER_x < LAT_x - 1 so the steps end before commit.
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int LAT_MUL  = 19,
    parameter int LAT_DIV  = 21,
    parameter int ITER_MUL = 8,
    parameter int ITER_DIV = 16,
    parameter int CNT_W    = 5,
    parameter int IT_W     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] opcode_i,
    output logic       load_o,
    output op_e        load_op_o,
    output op_e        op_o,
    output logic       step_o,
    output logic       commit_o,
    output logic       busy_o,
    output logic       done_o
);

    logic             busy_q;
    logic             done_q;
    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IT_W-1:0]  iter_q;
    logic             dec_valid;
    op_e              dec_op;

    // Opcode decode: recognise the two supported instructions.
    always_comb begin
        dec_valid = (opcode_i == OPC_MULU) || (opcode_i == OPC_DIVU);
        dec_op    = (opcode_i == OPC_DIVU) ? OP_DIV : OP_MUL;
    end

    // Strobes derived from the sequencing state.
    always_comb begin
        load_o    = start_i && !busy_q && dec_valid;
        load_op_o = dec_op;
        step_o    = busy_q && (iter_q != '0);
        commit_o  = busy_q && (cnt_q == CNT_W'(1));
    end

    // Sequencing registers: busy flag, countdowns, latched operation, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            op_q   <= OP_MUL;
            cnt_q  <= '0;
            iter_q <= '0;
        end else begin
            done_q <= commit_o;
            if (load_o) begin
                busy_q <= 1'b1;
                op_q   <= dec_op;
                cnt_q  <= (dec_op == OP_DIV) ? CNT_W'(LAT_DIV) : CNT_W'(LAT_MUL);
                iter_q <= (dec_op == OP_DIV) ? IT_W'(ITER_DIV) : IT_W'(ITER_MUL);
            end else if (busy_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (iter_q != '0) begin
                    iter_q <= iter_q - IT_W'(1);
                end
                if (commit_o) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign op_o   = op_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/muldiv_path.sv
// Module: shared radix-2 datapath.
// One adder/subtractor of DW+2 bits serves two algorithms:
//  - multiply: shift-add, where the high half accumulates and the low half
//    holds the multiplier;
//  - divide: restoring shift-subtract, where the high part is the partial
//    remainder and the 2*DW shift register turns dividend into quotient.
// Assumes the control asserts step_i exactly ITER times after load_i.
module muldiv_path
    import muldiv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  op_e           load_op_i,
    input  op_e           op_i,
    input  logic          step_i,
    input  logic [2*DW-1:0] a_i,
    input  logic [2*DW-1:0] t_i,
    output logic [2*DW-1:0] prod_o,
    output logic [DW-1:0]   quo_o,
    output logic [DW-1:0]   rem_o,
    output logic [2*DW-1:0] t_keep_o,
    output logic            divisor_zero_o
);

    localparam int WW = 2 * DW;
    localparam int RW = DW + 2;

    logic [DW:0]   hi_q;
    logic [WW-1:0] lo_q;
    logic [DW-1:0] b_q;
    logic [WW-1:0] t_keep_q;

    logic          is_mul;
    logic [DW:0]   x_op;
    logic [DW:0]   y_op;
    logic [RW-1:0] res;
    logic          no_borrow;

    // Operand selection and the single shared add/subtract.
    always_comb begin
        is_mul = (op_i == OP_MUL);
        if (is_mul) begin
            x_op = {1'b0, hi_q[DW-1:0]};
            y_op = lo_q[0] ? {1'b0, b_q} : '0;
            res  = {1'b0, x_op} + {1'b0, y_op};
        end else begin
            x_op = {hi_q[DW-1:0], lo_q[WW-1]};
            y_op = {1'b0, b_q};
            res  = {1'b0, x_op} - {1'b0, y_op};
        end
        no_borrow = ~res[RW-1];
    end

    // Working registers: load operands, then one radix-2 step per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            b_q      <= '0;
            t_keep_q <= '0;
        end else if (load_i) begin
            hi_q     <= '0;
            t_keep_q <= t_i;
            if (load_op_i == OP_MUL) begin
                lo_q <= {{DW{1'b0}}, a_i[DW-1:0]};
                b_q  <= t_i[DW-1:0];
            end else begin
                lo_q <= t_i;
                b_q  <= a_i[DW-1:0];
            end
        end else if (step_i) begin
            if (is_mul) begin
                hi_q <= {1'b0, res[DW:1]};
                lo_q <= {lo_q[WW-1:DW], res[0], lo_q[DW-1:1]};
            end else begin
                hi_q <= no_borrow ? res[DW:0] : x_op;
                lo_q <= {lo_q[WW-2:0], no_borrow};
            end
        end
    end

    assign prod_o         = {hi_q[DW-1:0], lo_q[DW-1:0]};
    assign quo_o          = lo_q[DW-1:0];
    assign rem_o          = hi_q[DW-1:0];
    assign t_keep_o       = t_keep_q;
    assign divisor_zero_o = (b_q == '0);

endmodule

// File: rtl/muldiv_flags.sv
// Module: flag values and per-flag write-enables for a finished operation.
// Multiply updates all four flags from the product. Divide updates none.
// Assumes the caller samples the outputs only in the commit cycle.
module muldiv_flags
    import muldiv_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e             op_i,
    input  logic [2*DW-1:0] prod_i,
    output flags_t          flags_o,
    output logic [3:0]      we_o
);

    localparam int NFLAG = 4;

    // Flag values computed from the product.
    always_comb begin
        flags_o.n = prod_i[2*DW-1];
        flags_o.z = (prod_i == '0);
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
    end

    // One write-enable per flag, high only for the multiply.
    for (genvar g = 0; g < NFLAG; g++) begin : g_we
        assign we_o[g] = (op_i == OP_MUL);
    end

endmodule

// File: rtl/muldiv_unit.sv
// Module: top of the sequential multiply/divide unit.
// It wires control, datapath and flag logic together and holds the output
// registers, which change only on the commit edge. Assumes an 8-bit data
// byte, so A and T are 16 bits wide.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DW       = 8,
    parameter int LAT_MUL  = 19,
    parameter int LAT_DIV  = 21,
    parameter int ITER_MUL = DW,
    parameter int ITER_DIV = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [7:0]      opcode_i,
    input  logic [2*DW-1:0] a_i,
    input  logic [2*DW-1:0] t_i,
    output logic [2*DW-1:0] a_o,
    output logic [2*DW-1:0] t_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            div_zero_o,
    output logic            flag_n_o,
    output logic            flag_z_o,
    output logic            flag_v_o,
    output logic            flag_c_o,
    output logic            we_n_o,
    output logic            we_z_o,
    output logic            we_v_o,
    output logic            we_c_o
);

    localparam int WW      = 2 * DW;
    localparam int LAT_MAX = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int IT_MAX  = (ITER_MUL > ITER_DIV) ? ITER_MUL : ITER_DIV;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam int IT_W    = $clog2(IT_MAX + 1);

    logic          load;
    op_e           load_op;
    op_e           op_cur;
    logic          step;
    logic          commit;
    logic [WW-1:0] prod;
    logic [DW-1:0] quo;
    logic [DW-1:0] rem;
    logic [WW-1:0] t_keep;
    logic          dz;
    flags_t        flg_new;
    logic [3:0]    we_new;

    logic [WW-1:0] a_q;
    logic [WW-1:0] t_q;
    flags_t        flg_q;
    logic [3:0]    we_q;
    logic          dz_q;

    muldiv_ctrl #(
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV),
        .ITER_MUL(ITER_MUL),
        .ITER_DIV(ITER_DIV),
        .CNT_W   (CNT_W),
        .IT_W    (IT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opcode_i (opcode_i),
        .load_o   (load),
        .load_op_o(load_op),
        .op_o     (op_cur),
        .step_o   (step),
        .commit_o (commit),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    muldiv_path #(
        .DW(DW)
    ) path_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .load_op_i     (load_op),
        .op_i          (op_cur),
        .step_i        (step),
        .a_i           (a_i),
        .t_i           (t_i),
        .prod_o        (prod),
        .quo_o         (quo),
        .rem_o         (rem),
        .t_keep_o      (t_keep),
        .divisor_zero_o(dz)
    );

    muldiv_flags #(
        .DW(DW)
    ) flags_i (
        .op_i   (op_cur),
        .prod_i (prod),
        .flags_o(flg_new),
        .we_o   (we_new)
    );

    // Output registers: commit results on the commit edge, pulse enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            t_q   <= '0;
            flg_q <= '0;
            we_q  <= '0;
            dz_q  <= 1'b0;
        end else if (commit) begin
            we_q <= we_new;
            if (op_cur == OP_MUL) begin
                a_q   <= prod;
                t_q   <= t_keep;
                flg_q <= flg_new;
                dz_q  <= 1'b0;
            end else if (dz) begin
                a_q  <= {{DW{1'b0}}, {DW{1'b1}}};
                t_q  <= t_keep;
                dz_q <= 1'b1;
            end else begin
                a_q  <= {{DW{1'b0}}, quo};
                t_q  <= {{DW{1'b0}}, rem};
                dz_q <= 1'b0;
            end
        end else begin
            we_q <= '0;
            dz_q <= 1'b0;
        end
    end

    assign a_o        = a_q;
    assign t_o        = t_q;
    assign div_zero_o = dz_q;
    assign flag_n_o   = flg_q.n;
    assign flag_z_o   = flg_q.z;
    assign flag_v_o   = flg_q.v;
    assign flag_c_o   = flg_q.c;
    assign we_n_o     = we_q[3];
    assign we_z_o     = we_q[2];
    assign we_v_o     = we_q[1];
    assign we_c_o     = we_q[0];

endmodule

// File: rtl/muldiv_unit_chk.sv
// Checker: port-level properties of muldiv_unit, attached by bind.
// A busy-cycle counter measures each operation's latency without a long
// $past window.
module muldiv_unit_chk #(
    parameter int DW      = 8,
    parameter int LAT_MUL = 19,
    parameter int LAT_DIV = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [7:0]      opcode_i,
    input logic [2*DW-1:0] a_o,
    input logic [2*DW-1:0] t_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            div_zero_o,
    input logic            flag_n_o,
    input logic            flag_z_o,
    input logic            flag_v_o,
    input logic            flag_c_o,
    input logic            we_n_o,
    input logic            we_z_o,
    input logic            we_v_o,
    input logic            we_c_o
);

    logic [6:0] busy_cyc;

    // Count busy cycles; the count equals the latency in the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cyc <= '0;
        end else if (busy_o) begin
            busy_cyc <= (busy_cyc == 7'h7F) ? busy_cyc : busy_cyc + 7'd1;
        end else begin
            busy_cyc <= '0;
        end
    end

    p_mul_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && we_n_o) |-> (busy_cyc == 7'(LAT_MUL)));

    p_div_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !we_n_o) |-> (busy_cyc == 7'(LAT_DIV)));

    p_div_zero_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (done_o && a_o == {{DW{1'b0}}, {DW{1'b1}}}));

    p_mul_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_z_o |-> (flag_z_o == (a_o == '0) && flag_n_o == a_o[2*DW-1]
                    && !flag_v_o && !flag_c_o));

    p_we_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n_o || we_z_o || we_v_o || we_c_o) |-> done_o);

    p_start_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (busy_o || done_o));

    p_bad_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && opcode_i != 8'h01 && opcode_i != 8'h11)
        |=> !busy_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_ends_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_hold_results_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(a_o) && $stable(t_o) && $stable(flag_n_o)
                     && $stable(flag_z_o)));

endmodule

bind muldiv_unit muldiv_unit_chk #(
    .DW     (DW),
    .LAT_MUL(LAT_MUL),
    .LAT_DIV(LAT_DIV)
) chk_i (.*);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
// Bench: swept multiply and divide operands, with expected values from
// plain arithmetic, exact latency timing and ignored-start cases.
module muldiv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] a_in = '0;
    logic [15:0] t_in = '0;
    logic [15:0] a_o, t_o;
    logic        busy_o, done_o, div_zero_o;
    logic        fn, fz, fv, fc, wn, wz, wv, wc;

    int checks = 0;
    int failures = 0;
    int op_count = 0;

    always #4 clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opcode),
        .a_i(a_in), .t_i(t_in), .a_o(a_o), .t_o(t_o),
        .busy_o(busy_o), .done_o(done_o), .div_zero_o(div_zero_o),
        .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc),
        .we_n_o(wn), .we_z_o(wz), .we_v_o(wv), .we_c_o(wc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one operation; poke adds extra starts while busy (R8).
    task automatic run_op(input logic [7:0] opc, input logic [15:0] a,
                          input logic [15:0] t, input bit poke);
        int lat;
        bit early;
        logic [15:0] ea, et;
        logic [7:0]  al, tl;
        logic [15:0] q, r;
        bit is_div, dz;
        string rq;
        is_div = (opc == 8'h11);
        lat = is_div ? 21 : 19;
        rq = is_div ? "R4" : "R2";
        al = a[7:0];
        tl = t[7:0];
        dz = is_div && (al == 8'h00);
        if (!is_div) begin
            ea = 16'(al) * 16'(tl);
            et = t;
        end else if (dz) begin
            ea = 16'h00FF;
            et = t;
        end else begin
            q = t / 16'(al);
            r = t % 16'(al);
            ea = {8'h00, q[7:0]};
            et = {8'h00, r[7:0]};
        end
        @(negedge clk);
        start = 1'b1; opcode = opc; a_in = a; t_in = t;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; a_in = ~a; t_in = ~t;
        chk(busy_o == 1'b1, "R10", "busy after accept", 32'(busy_o), 32'd1);
        early = 1'b0;
        for (int i = 1; i < lat; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done_o) early = 1'b1;
            if (poke && i >= 2 && i <= 4) begin
                start = 1'b1;
                opcode = is_div ? 8'h01 : 8'h11;
                a_in = 16'h1234; t_in = 16'h5678;
            end else begin
                start = 1'b0;
            end
        end
        chk(!early, rq, "done before latency", 32'(early), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b1, rq, "done at latency", 32'(done_o), 32'd1);
        chk(busy_o == 1'b0, "R10", "busy cleared at done", 32'(busy_o), 32'd0);
        if (!is_div) begin
            chk(a_o == ea, poke ? "R8" : "R1", "product", 32'(a_o), 32'(ea));
            chk(t_o == et, "R1", "T kept", 32'(t_o), 32'(et));
            chk({wn, wz, wv, wc} == 4'hF, "R6", "flag enables",
                32'({wn, wz, wv, wc}), 32'hF);
            chk({fn, fz, fv, fc} == {ea[15], ea == 16'h0, 2'b00}, "R6", "flags",
                32'({fn, fz, fv, fc}), 32'({ea[15], ea == 16'h0, 2'b00}));
        end else begin
            chk(a_o == ea, dz ? "R5" : (poke ? "R8" : "R3"), "quotient",
                32'(a_o), 32'(ea));
            chk(t_o == et, dz ? "R5" : "R3", "remainder", 32'(t_o), 32'(et));
            chk(div_zero_o == dz, "R5", "div_zero", 32'(div_zero_o), 32'(dz));
            chk({wn, wz, wv, wc} == 4'h0, "R7", "no flag enables",
                32'({wn, wz, wv, wc}), 32'h0);
        end
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0 && {wn, wz, wv, wc} == 4'h0, "R10", "done one cycle",
            32'({done_o, wn, wz, wv, wc}), 32'h0);
        chk(a_o == ea && t_o == et, "R10", "results held",
            32'({a_o, t_o}), 32'({ea, et}));
        op_count++;
    endtask

    initial begin
        logic [15:0] ha, ht;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && a_o == 0 && t_o == 0 && div_zero_o == 0
            && {fn, fz, fv, fc, wn, wz, wv, wc} == 8'h00, "R11", "reset state",
            32'({busy_o, done_o, div_zero_o, fn, fz, fv, fc, wn, wz, wv, wc}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R6: corner multiplies, then a swept grid.
        run_op(8'h01, 16'hAAFF, 16'h55FF, 1'b0);
        run_op(8'h01, 16'hFF00, 16'hFF7F, 1'b0);
        run_op(8'h01, 16'h0080, 16'h0002, 1'b1);
        for (int av = 0; av < 256; av += 5) begin
            for (int tv = 0; tv < 256; tv += 7) begin
                run_op(8'h01, {8'(av) ^ 8'h3C, 8'(av)}, {8'(tv) ^ 8'hC3, 8'(tv)},
                       (op_count % 7) == 0);
            end
        end

        // R3/R4/R5: corner divides, then a swept grid including zero divisor.
        run_op(8'h11, 16'h7701, 16'hFFFF, 1'b0);
        run_op(8'h11, 16'h00FF, 16'h00FE, 1'b0);
        run_op(8'h11, 16'h9900, 16'hBEEF, 1'b1);
        for (int tv = 0; tv < 65536; tv += 1237) begin
            for (int dv = 0; dv < 256; dv += 4) begin
                run_op(8'h11, {8'hA5, 8'(dv)}, 16'(tv), (op_count % 7) == 0);
            end
        end
        run_op(8'h11, 16'h00FF, 16'hFFFF, 1'b0);

        // R9: unknown opcodes are ignored.
        ha = a_o;
        ht = t_o;
        foreach (ha[i]) begin end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start = 1'b1;
            opcode = (k == 0) ? 8'h23 : ((k == 1) ? 8'h00 : 8'h10);
            a_in = 16'h0203; t_in = 16'h0405;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            chk(busy_o == 1'b0, "R9", "busy after bad opcode", 32'(busy_o), 32'd0);
            for (int w = 0; w < 24; w++) begin
                @(posedge clk);
                @(negedge clk);
                if (done_o) chk(1'b0, "R9", "done after bad opcode", 32'd1, 32'd0);
            end
            chk(a_o == ha && t_o == ht, "R9", "outputs unchanged",
                32'({a_o, t_o}), 32'({ha, ht}));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule